// File: doc/BRIEF.md
# Packetizing 64-QAM Symbol Mapper

The block turns a serial payload bit stream into a stream of 64-QAM constellation points. After a start request it emits a programmable number of packets. Each packet opens with a fixed preamble and then carries a fixed number of payload bits. The payload bits are whitened by an additive scrambler, and the scrambler is reseeded at every packet.

Bits from the preamble and from the scrambled payload are collected six at a time. Each six-bit word becomes one symbol: a signed in-phase level and a signed quadrature level, both from the odd set -7 to +7. A payload whose length is not a multiple of six closes with a zero-padded symbol. The output is a registered valid/ready stream, and the upstream bit handshake stalls whenever the output register cannot accept a new symbol.

Top module: `qam64_packetizer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `sym_valid_o` and `bit_ready_o` are both 0.
- R2: A `start_i` pulse while idle with `pkt_count_i` = N > 0 yields exactly N packets. Each packet is PREAMBLE_BITS/6 preamble symbols followed by ceil(DATA_BITS/6) payload symbols. With N = 0 the block produces no symbol and requests no bit.
- R3: Every packet begins with the PREAMBLE_BITS-bit preamble constant, sent most significant bit first and not scrambled. `bit_ready_o` stays 0 for the whole preamble.
- R4: Each accepted payload bit is XORed with the scrambler output f = s[6] ^ s[3], where s is a 7-bit register of the polynomial x^7+x^4+1. After each accepted bit the register becomes {s[5:0], f}. It is set to 7'h7F at the start of every packet.
- R5: The first bit collected into a word becomes bit 5 of the six-bit word and the sixth becomes bit 0. Preamble and payload share this grouping, so symbol boundaries line up with the packet start.
- R6: Word bits [5:3] select the in-phase level and bits [2:0] the quadrature level. The Gray codes 000, 001, 011, 010, 110, 111, 101, 100 give the levels -7, -5, -3, -1, +1, +3, +5, +7, output as 4-bit two's complement.
- R7: If a packet's payload ends inside a word, the missing low-order bits of that last word are zero.
- R8: While `sym_valid_o` is 1 and `sym_ready_i` is 0, the symbol and its valid flag hold unchanged in the next cycle.
- R9: A `start_i` pulse while packets are being produced has no effect on the symbols produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a burst of packets when idle |
| pkt_count_i | input | PKT_W | Number of packets in the burst |
| bit_i | input | 1 | Serial payload bit |
| bit_valid_i | input | 1 | Payload bit is present |
| bit_ready_o | output | 1 | Block accepts a payload bit this cycle |
| sym_i_o | output | 4 | In-phase level, signed |
| sym_q_o | output | 4 | Quadrature level, signed |
| sym_valid_o | output | 1 | Symbol output is valid |
| sym_ready_i | input | 1 | Downstream accepts the symbol |

## Verification
Two events can land in the same cycle: the last payload bit of a packet closes a zero-padded word, and the scrambler is reseeded for the next packet's preamble. The bench provokes this with back-to-back packets whose payload length is not a multiple of six. It runs these packets under random input gaps and random output backpressure. The arithmetic reference model computes every symbol of every packet, so a wrong pad, a missed reseed or a lost bit at that boundary shows up as a symbol mismatch in the following packet.

// File: rtl/qam64_pkg.sv
package qam64_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PRE  = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    localparam int WORD_BITS = 6;
    localparam int AXIS_BITS = 3;
    localparam int LEVEL_W   = 4;

    function automatic logic [AXIS_BITS-1:0] gray_to_index(input logic [AXIS_BITS-1:0] g);
        logic [AXIS_BITS-1:0] b;
        b[AXIS_BITS-1] = g[AXIS_BITS-1];
        for (int k = AXIS_BITS - 2; k >= 0; k--) begin
            b[k] = b[k+1] ^ g[k];
        end
        return b;
    endfunction

endpackage

// File: rtl/qam64_whitener.sv
module qam64_whitener #(
    parameter int          LFSR_W = 7,
    parameter int          TAP_HI = 6,
    parameter int          TAP_LO = 3,
    parameter logic [6:0]  SEED   = 7'h7F
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reseed_i,
    input  logic advance_i,
    output logic key_o
);
    logic [LFSR_W-1:0] reg_d, reg_q;

    always_comb begin
        key_o = reg_q[TAP_HI] ^ reg_q[TAP_LO];
        reg_d = reg_q;
        if (reseed_i) begin
            reg_d = SEED;
        end else if (advance_i) begin
            reg_d = {reg_q[LFSR_W-2:0], key_o};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) reg_q <= SEED;
        else        reg_q <= reg_d;
    end

    // R4: a reseed request leaves the register at the seed value
    assert_reseed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reseed_i |=> (reg_q == SEED));

endmodule

// File: rtl/qam64_axis_map.sv
module qam64_axis_map
    import qam64_pkg::*;
(
    input  logic [AXIS_BITS-1:0] code_i,
    output logic [LEVEL_W-1:0]   level_o
);
    logic [AXIS_BITS-1:0] idx;

    always_comb begin
        idx = gray_to_index(code_i);
        // level = 2*idx - 7 in two's complement
        level_o = {~idx[AXIS_BITS-1], idx[AXIS_BITS-2:0], 1'b1};
    end

endmodule

// File: rtl/qam64_packetizer.sv
module qam64_packetizer
    import qam64_pkg::*;
#(
    parameter int                       PKT_W         = 4,
    parameter int                       DATA_BITS     = 16,
    parameter int                       PREAMBLE_BITS = 24,
    parameter logic [PREAMBLE_BITS-1:0] PREAMBLE      = 24'hC35AE1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [PKT_W-1:0] pkt_count_i,
    input  logic             bit_i,
    input  logic             bit_valid_i,
    output logic             bit_ready_o,
    output logic [3:0]       sym_i_o,
    output logic [3:0]       sym_q_o,
    output logic             sym_valid_o,
    input  logic             sym_ready_i
);
    localparam int POS_MAX = (PREAMBLE_BITS > DATA_BITS) ? PREAMBLE_BITS : DATA_BITS;
    localparam int POS_W   = $clog2(POS_MAX + 1);
    localparam logic [POS_W-1:0] PRE_LAST  = POS_W'(PREAMBLE_BITS - 1);
    localparam logic [POS_W-1:0] DATA_LAST = POS_W'(DATA_BITS - 1);

    typedef struct packed {
        phase_e                 ph;
        logic [PKT_W-1:0]       left;
        logic [POS_W-1:0]       pos;
        logic [2:0]             fill;
        logic [WORD_BITS-2:0]   acc;
        logic                   vld;
        logic [LEVEL_W-1:0]     si;
        logic [LEVEL_W-1:0]     sq;
    } ctl_t;

    ctl_t r_d, r_q;

    logic                 slot_free, take, in_pre, in_data, cur_bit, key;
    logic                 word_done, reseed, advance;
    logic [POS_W-1:0]     pre_idx;
    logic [WORD_BITS-1:0] word_raw, word_out;
    logic [LEVEL_W-1:0]   lvl_i, lvl_q;

    qam64_whitener u_whiten (
        .clk       (clk),
        .rst_n     (rst_n),
        .reseed_i  (reseed),
        .advance_i (advance),
        .key_o     (key)
    );

    qam64_axis_map u_map_i (.code_i(word_out[5:3]), .level_o(lvl_i));
    qam64_axis_map u_map_q (.code_i(word_out[2:0]), .level_o(lvl_q));

    always_comb begin
        in_pre    = (r_q.ph == PH_PRE);
        in_data   = (r_q.ph == PH_DATA);
        slot_free = !r_q.vld || sym_ready_i;
        take      = slot_free && (in_pre || (in_data && bit_valid_i));
        pre_idx   = PRE_LAST - r_q.pos;
        cur_bit   = in_pre ? PREAMBLE[pre_idx] : (bit_i ^ key);
        word_raw  = {r_q.acc, cur_bit};
        word_done = (r_q.fill == 3'd5) || (in_data && r_q.pos == DATA_LAST);
        word_out  = word_raw << (3'd5 - r_q.fill);
        advance   = in_data && take;
        reseed    = 1'b0;

        r_d = r_q;
        if (sym_ready_i) r_d.vld = 1'b0;

        if (take) begin
            if (word_done) begin
                r_d.vld  = 1'b1;
                r_d.si   = lvl_i;
                r_d.sq   = lvl_q;
                r_d.fill = 3'd0;
                r_d.acc  = '0;
            end else begin
                r_d.acc  = word_raw[WORD_BITS-2:0];
                r_d.fill = r_q.fill + 3'd1;
            end
        end

        unique case (r_q.ph)
            PH_IDLE: begin
                if (start_i && pkt_count_i != '0) begin
                    r_d.ph   = PH_PRE;
                    r_d.left = pkt_count_i;
                    r_d.pos  = '0;
                    reseed   = 1'b1;
                end
            end
            PH_PRE: begin
                if (take) begin
                    if (r_q.pos == PRE_LAST) begin
                        r_d.ph  = PH_DATA;
                        r_d.pos = '0;
                    end else begin
                        r_d.pos = r_q.pos + 1'b1;
                    end
                end
            end
            PH_DATA: begin
                if (take) begin
                    if (r_q.pos == DATA_LAST) begin
                        r_d.pos  = '0;
                        r_d.left = r_q.left - 1'b1;
                        if (r_q.left == PKT_W'(1)) begin
                            r_d.ph = PH_IDLE;
                        end else begin
                            r_d.ph = PH_PRE;
                            reseed = 1'b1;
                        end
                    end else begin
                        r_d.pos = r_q.pos + 1'b1;
                    end
                end
            end
            default: r_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.ph   <= PH_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign bit_ready_o = slot_free && in_data;
    assign sym_i_o     = r_q.si;
    assign sym_q_o     = r_q.sq;
    assign sym_valid_o = r_q.vld;

    // R8: a stalled symbol keeps its value and valid flag
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid_o && !sym_ready_i) |=> (sym_valid_o && $stable(sym_i_o) && $stable(sym_q_o)));

    // R9: while busy the packet budget only moves by one per finished packet
    assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ph != PH_IDLE) |=> (r_q.left == $past(r_q.left) || r_q.left == $past(r_q.left) - 1'b1));

    // R5: payload grouping starts on a fresh word after the preamble
    assert_word_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_pre && r_d.ph == PH_DATA) |=> (r_q.fill == 3'd0));

    // R2: an idle block with an empty output creates no symbol without a start
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ph == PH_IDLE && !sym_valid_o && !start_i) |=> !sym_valid_o);

    // R3: the payload bit counter never passes the packet length
    assert_pos_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_data |-> (r_q.pos <= DATA_LAST));

endmodule

// File: tb/qam64_packetizer_test.sv
module qam64_packetizer_test;
    localparam int PKT_W = 4;
    localparam int DATA_BITS = 16;
    localparam int PRE_BITS = 24;
    localparam logic [PRE_BITS-1:0] PRE = 24'hC35AE1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [PKT_W-1:0] pkt_count_i = '0;
    logic bit_i = 1'b0, bit_valid_i = 1'b0, sym_ready_i = 1'b0;
    logic bit_ready_o, sym_valid_o;
    logic [3:0] sym_i_o, sym_q_o;

    int checks = 0;
    int errors = 0;

    logic data_q[$];
    int   exp_i[$];
    int   exp_q[$];

    always #5 clk = ~clk;

    qam64_packetizer #(.PKT_W(PKT_W), .DATA_BITS(DATA_BITS),
                       .PREAMBLE_BITS(PRE_BITS), .PREAMBLE(PRE)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .pkt_count_i(pkt_count_i),
        .bit_i(bit_i), .bit_valid_i(bit_valid_i), .bit_ready_o(bit_ready_o),
        .sym_i_o(sym_i_o), .sym_q_o(sym_q_o), .sym_valid_o(sym_valid_o),
        .sym_ready_i(sym_ready_i)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, expv);
        end
    endtask

    // R6: Gray code to odd level, computed arithmetically
    function automatic int level_of(input int g);
        int b2, b1, b0;
        b2 = (g >> 2) & 1;
        b1 = b2 ^ ((g >> 1) & 1);
        b0 = b1 ^ (g & 1);
        return 2 * (b2 * 4 + b1 * 2 + b0) - 7;
    endfunction

    function automatic int sgn4(input logic [3:0] v);
        return int'($signed(v));
    endfunction

    // Builds payload and expected symbols for n packets (R3, R4, R5, R7)
    task automatic build(input int n);
        for (int p = 0; p < n; p++) begin
            logic [6:0] s;
            int bits[$];
            s = 7'h7F;
            for (int k = PRE_BITS - 1; k >= 0; k--) bits.push_back(int'(PRE[k]));
            for (int k = 0; k < DATA_BITS; k++) begin
                logic d, f;
                d = logic'($urandom % 2);
                data_q.push_back(d);
                f = s[6] ^ s[3];
                s = {s[5:0], f};
                bits.push_back(int'(d ^ f));
            end
            while (bits.size() % 6 != 0) bits.push_back(0);
            for (int w = 0; w < bits.size(); w += 6) begin
                int word;
                word = 0;
                for (int k = 0; k < 6; k++) word = word * 2 + bits[w + k];
                exp_i.push_back(level_of(word >> 3));
                exp_q.push_back(level_of(word & 7));
            end
        end
    endtask

    // Runs one burst; vmode/rmode 0 = always on, 1 = random gaps
    task automatic run(input int n, input int vmode, input int rmode, input int restart_at);
        int k;
        bit stall;
        logic [3:0] hi, hq;
        build(n);
        @(negedge clk);
        start_i = 1'b1;
        pkt_count_i = PKT_W'(n);
        @(negedge clk);
        start_i = 1'b0;
        k = 0;
        stall = 1'b0;
        hi = '0;
        hq = '0;
        while ((exp_i.size() != 0 || data_q.size() != 0) && k < 5000) begin
            if (k > 0) @(negedge clk);
            if (k == restart_at) begin
                start_i = 1'b1;
                pkt_count_i = PKT_W'(5);
            end else begin
                start_i = 1'b0;
            end
            bit_valid_i = (data_q.size() != 0) && (vmode == 0 || ($urandom % 4) != 0);
            bit_i = (data_q.size() != 0) ? data_q[0] : 1'b0;
            sym_ready_i = (rmode == 0) || (($urandom % 3) != 0);
            #4;
            if (vmode == 0 && rmode == 0 && k < PRE_BITS)
                check(!bit_ready_o, "R3 ready during preamble", int'(bit_ready_o), 0);
            if (vmode == 0 && rmode == 0 && k == PRE_BITS)
                check(bit_ready_o, "R3 ready after preamble", int'(bit_ready_o), 1);
            if (stall) begin
                check(sym_valid_o && sym_i_o == hi && sym_q_o == hq, "R8 hold",
                      sgn4(sym_i_o), sgn4(hi));
            end
            if (bit_valid_i && bit_ready_o) void'(data_q.pop_front());
            if (sym_valid_o && sym_ready_i) begin
                if (exp_i.size() == 0) begin
                    check(1'b0, "R2 extra symbol", sgn4(sym_i_o), 0);
                end else begin
                    int ei, eq;
                    ei = exp_i.pop_front();
                    eq = exp_q.pop_front();
                    check(sgn4(sym_i_o) == ei, "R6 I level", sgn4(sym_i_o), ei);
                    check(sgn4(sym_q_o) == eq, "R6 Q level", sgn4(sym_q_o), eq);
                end
            end
            stall = sym_valid_o && !sym_ready_i;
            hi = sym_i_o;
            hq = sym_q_o;
            k++;
        end
        check(k < 5000, "watchdog", k, 5000);
        start_i = 1'b0;
        bit_valid_i = 1'b0;
        sym_ready_i = 1'b1;
        // R2/R9: nothing follows the burst
        for (int c = 0; c < 60; c++) begin
            @(negedge clk);
            #4;
            if (sym_valid_o) check(1'b0, "R9 symbol after burst", 1, 0);
        end
        check(!sym_valid_o && !bit_ready_o, "R2 idle after burst", int'(sym_valid_o), 0);
        exp_i.delete();
        exp_q.delete();
        data_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #4;
        check(!sym_valid_o && !bit_ready_o, "R1 reset", int'(sym_valid_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #4;
        check(!sym_valid_o && !bit_ready_o, "R1 after reset", int'(bit_ready_o), 0);

        // R2: zero packet count does nothing
        @(negedge clk);
        start_i = 1'b1;
        pkt_count_i = '0;
        bit_valid_i = 1'b1;
        sym_ready_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            #4;
            if (sym_valid_o || bit_ready_o) check(1'b0, "R2 count zero", 1, 0);
        end
        check(!sym_valid_o && !bit_ready_o, "R2 count zero idle", int'(sym_valid_o), 0);
        bit_valid_i = 1'b0;

        run(1, 0, 0, -1);          // R3 R4 R5 R6 R7 single packet, no gaps
        run(3, 0, 0, -1);          // R4 reseed across back-to-back packets
        run(4, 1, 1, -1);          // R8 backpressure with input gaps
        run(2, 1, 1, 30);          // R9 start pulse while busy
        for (int r = 0; r < 4; r++) run(r + 2, 1, 1, -1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1500000;
        errors++;
        checks++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule